// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits at the front of a receive path and decides, frame by frame, whether the frame is kept or discarded, based only on its destination MAC address. Header bytes arrive one per handshake on a valid/ready byte stream, with a start-of-frame flag on the first byte. The block keeps the first six bytes and folds them into a CRC-32 as they arrive. Once the sixth byte has been taken, it issues a one-cycle decision pulse together with an accept flag.

Three sources can make a frame acceptable. The first is a bank of seventeen exact-match address slots: a primary station slot 0 plus sixteen extra slots 1..16, each with its own enable. The second is a 64-bin multicast hash table indexed from the address CRC. The third is a set of mode bits in a control register: promiscuous, receive-all, pass-all-multicast, hash-multicast and broadcast-disable. All registers sit behind a simple word-write port.

Back-pressure rules: `in_ready` is low while reset is asserted. It is high from the first clock edge after reset is released and stays high, so the block never stalls the stream. A byte counts only on a cycle where `in_valid` and `in_ready` are both high. The source may insert idle cycles between bytes at will.

Top module: `rx_da_filter`

## Requirements
- R1: `in_ready` is high in every cycle from the first edge after reset release. A byte is consumed only when `in_valid` and `in_ready` are both high. A byte flagged by `in_sof` is destination byte 0. Up to five following unflagged bytes are bytes 1..5. Unflagged bytes after the sixth, or before any flagged byte, are ignored and cause no decision.
- R2: `dec_valid` is high for exactly one cycle per captured address. That cycle is the second clock cycle after the edge that consumes byte 5. `dec_accept` is meaningful in that cycle.
- R3: A flagged byte arriving while an address is partly captured discards the partial address and restarts capture. Only the restarted address yields a decision.
- R4: Slot n (n = 0..16) is written as a low word at register 16+2n and a high word at 17+2n. The low word holds bytes 0..3, with byte 0 in bits 7:0. The high word holds byte 4 in bits 7:0, byte 5 in bits 15:8 and the slot enable in bit 31. A non-group address is accepted iff it equals an enabled slot. A disabled slot never matches.
- R5: The control register is at address 0, with bit 0 promiscuous, bit 1 hash-multicast, bit 2 pass-all-multicast, bit 3 broadcast-disable and bit 4 receive-all. The hash table low half is at address 1 and the high half at address 2.
- R6: The hash index is taken from the CRC-32 over the six bytes. The CRC uses the reflected polynomial 0xEDB88320, starts at all ones and takes each byte LSB first. The index is the top six bits of the bit-reversed complement of the final CRC. Index bit 5 selects the high (1) or low (0) half, and bits 4:0 select the bit within that half.
- R7: With hash-multicast set, a group address (byte 0 bit 0 = 1, not all ones) is accepted if its hash table bit is 1, or if it matches an enabled slot. With hash-multicast clear, the table has no effect.
- R8: With pass-all-multicast set, every group address that is not broadcast is accepted regardless of the hash table.
- R9: The all-ones broadcast address is accepted when broadcast-disable is 0 and dropped when it is 1, unless R10 or R11 applies.
- R10: With promiscuous set, every address is accepted.
- R11: With receive-all set, every address is accepted.
- R12: After reset, the control and hash registers are zero, all slots are disabled and `dec_valid` is low, so a unicast address is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Header byte valid |
| in_ready | output | 1 | Filter ready to take a byte |
| in_data | input | 8 | Header byte |
| in_sof | input | 1 | Marks destination byte 0 |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Accept (1) or drop (0), valid with dec_valid |

## Verification
The hardest case to reach from the ports is a start-of-frame flag landing inside a half-captured address. Here the byte counter, the stored bytes and the running CRC must all restart together, and a stale decision must not leak out. The bench sends three bytes of an address that would be accepted, then immediately starts a second address that must be dropped, and expects exactly one decision with the second address's verdict. Stray unflagged bytes before the first start flag and after a complete address are also driven, to show that they produce no decision.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // Control register fields, LSB = promiscuous
  typedef struct packed {
    logic recv_all;
    logic bcast_off;
    logic pass_mc;
    logic hash_mc;
    logic promisc;
  } ctrl_t;

  localparam int unsigned RA_CTRL    = 0;
  localparam int unsigned RA_HASH_LO = 1;
  localparam int unsigned RA_HASH_HI = 2;
  localparam int unsigned RA_SLOT0   = 16;

  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

  // One byte of reflected CRC-32, LSB of the byte first
  function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    logic fb;
    c = c_in;
    for (int b = 0; b < 8; b++) begin
      fb = c[0] ^ d[b];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/rxf_addr_cap.sv
module rxf_addr_cap #(
  parameter int unsigned NBYTES = 6,
  parameter int unsigned IDX_W  = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  beat,
  input  logic                  sof,
  input  logic [7:0]            data,
  output logic [8*NBYTES-1:0]   da,
  output logic [IDX_W-1:0]      hash_idx,
  output logic                  done
);
  import rxf_pkg::*;

  localparam int unsigned CW = $clog2(NBYTES + 1);
  localparam logic [CW-1:0] IDLE = CW'(NBYTES);
  localparam logic [CW-1:0] LAST = CW'(NBYTES - 1);

  logic [CW-1:0] cnt_q;
  logic [31:0]   crc_q;
  logic [31:0]   crc_seed;
  logic          take;

  // A flagged byte always restarts; otherwise only while capture is open
  assign take     = beat && (sof || (cnt_q != IDLE));
  assign crc_seed = sof ? CRC_INIT : crc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= IDLE;
      crc_q <= CRC_INIT;
      da    <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (take) begin
        crc_q <= crc_step(crc_seed, data);
        if (sof) begin
          da[7:0] <= data;
          cnt_q   <= CW'(1);
          done    <= (NBYTES == 1);
        end else begin
          for (int i = 1; i < NBYTES; i++) begin
            if (cnt_q == CW'(i)) da[i*8 +: 8] <= data;
          end
          cnt_q <= cnt_q + CW'(1);
          done  <= (cnt_q == LAST);
        end
      end
    end
  end

  // Index = top bits of bitrev(~crc) = reversed, complemented low bits
  for (genvar k = 0; k < IDX_W; k++) begin : g_idx
    assign hash_idx[k] = ~crc_q[IDX_W-1-k];
  end

endmodule

// File: rtl/rxf_hash_table.sv
module rxf_hash_table #(
  parameter int unsigned AW    = 6,
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      wdata,
  input  logic [IDX_W-1:0] idx,
  output logic             bin_set
);
  import rxf_pkg::*;

  localparam int unsigned HALVES = (1 << IDX_W) / 32;

  logic [31:0] half_q [HALVES];

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    localparam logic [AW-1:0] HA = AW'(RA_HASH_LO + h);
    always_ff @(posedge clk) begin
      if (rst)                      half_q[h] <= '0;
      else if (we && (addr == HA))  half_q[h] <= wdata;
    end
  end

  assign bin_set = half_q[idx[IDX_W-1:5]][idx[4:0]];

endmodule

// File: rtl/rxf_slot_bank.sv
module rxf_slot_bank #(
  parameter int unsigned AW     = 6,
  parameter int unsigned NSLOTS = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wlo,
  input  logic [16:0]   whi,
  input  logic [47:0]   da,
  output logic          hit
);
  import rxf_pkg::*;

  logic [NSLOTS-1:0] slot_hit;

  for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
    localparam logic [AW-1:0] LO_A = AW'(RA_SLOT0 + 2*s);
    localparam logic [AW-1:0] HI_A = AW'(RA_SLOT0 + 2*s + 1);
    logic [31:0] lo_q;
    logic [15:0] hi_q;
    logic        en_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q <= '0;
        hi_q <= '0;
        en_q <= 1'b0;
      end else if (we) begin
        if (addr == LO_A) lo_q <= wlo;
        if (addr == HI_A) begin
          hi_q <= whi[15:0];
          en_q <= whi[16];
        end
      end
    end

    assign slot_hit[s] = en_q && (da == {hi_q, lo_q});
  end

  assign hit = |slot_hit;

endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter #(
  parameter int unsigned AW     = 6,
  parameter int unsigned NSLOTS = 17,
  parameter int unsigned IDX_W  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_sof,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic          dec_valid,
  output logic          dec_accept
);
  import rxf_pkg::*;

  localparam int unsigned NBYTES = 6;
  localparam int unsigned DA_W   = 8 * NBYTES;
  localparam logic [AW-1:0] CTRL_A = AW'(RA_CTRL);

  ctrl_t            ctrl_q;
  logic             rdy_q;
  logic [DA_W-1:0]  da_q;
  logic [IDX_W-1:0] idx;
  logic             cap_done;
  logic             bin_set;
  logic             slot_hit;
  logic             is_bcast;
  logic             is_group;
  logic             verdict;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q  <= 1'b0;
      ctrl_q <= '0;
    end else begin
      rdy_q <= 1'b1;
      if (cfg_we && (cfg_addr == CTRL_A)) ctrl_q <= ctrl_t'(cfg_wdata[4:0]);
    end
  end
  assign in_ready = rdy_q;

  rxf_addr_cap #(.NBYTES(NBYTES), .IDX_W(IDX_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .beat     (in_valid && rdy_q),
    .sof      (in_sof),
    .data     (in_data),
    .da       (da_q),
    .hash_idx (idx),
    .done     (cap_done)
  );

  rxf_hash_table #(.AW(AW), .IDX_W(IDX_W)) u_hash (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .idx     (idx),
    .bin_set (bin_set)
  );

  rxf_slot_bank #(.AW(AW), .NSLOTS(NSLOTS)) u_slots (
    .clk  (clk),
    .rst  (rst),
    .we   (cfg_we),
    .addr (cfg_addr),
    .wlo  (cfg_wdata),
    .whi  ({cfg_wdata[31], cfg_wdata[15:0]}),
    .da   (da_q),
    .hit  (slot_hit)
  );

  assign is_bcast = &da_q;
  assign is_group = da_q[0];

  always_comb begin
    if (ctrl_q.recv_all || ctrl_q.promisc)
      verdict = 1'b1;
    else if (is_bcast)
      verdict = !ctrl_q.bcast_off;
    else if (is_group)
      verdict = ctrl_q.pass_mc || (ctrl_q.hash_mc && bin_set) || slot_hit;
    else
      verdict = slot_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= cap_done;
      dec_accept <= cap_done && verdict;
    end
  end

endmodule

// File: rtl/rxf_filter_chk.sv
module rxf_filter_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic dec_valid,
  input logic dec_accept,
  input logic promisc,
  input logic recv_all,
  input logic uc_hit,
  input logic is_group
);

  // R2: a decision needs a byte taken two edges earlier
  p_dec_after_byte_r2: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(in_valid && in_ready, 2));

  // R2: the strobe lasts one cycle
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);

  // R10
  p_promisc_accept_r10: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && $past(promisc)) |-> dec_accept);

  // R11
  p_recv_all_accept_r11: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && $past(recv_all)) |-> dec_accept);

  // R4
  p_slot_hit_accept_r4: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && $past(uc_hit) && !$past(is_group)) |-> dec_accept);

  // R1
  p_ready_held_r1: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> in_ready);

endmodule

bind rx_da_filter rxf_filter_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .dec_valid  (dec_valid),
  .dec_accept (dec_accept),
  .promisc    (ctrl_q.promisc),
  .recv_all   (ctrl_q.recv_all),
  .uc_hit     (slot_hit),
  .is_group   (da_q[0])
);

// File: tb/tb_rx_da_filter.sv
module tb_rx_da_filter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_sof = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        dec_valid;
  logic        dec_accept;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  rx_da_filter dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  // Addresses: byte 0 (first on the stream) in bits 7:0
  localparam logic [47:0] UC_A  = 48'h5544_3322_1102;
  localparam logic [47:0] UC_B  = 48'h0F0E_0D0C_0B0A;
  localparam logic [47:0] UC_X  = 48'hABCD_EF12_3456;
  localparam logic [47:0] MC_A  = 48'h0100_005E_0001;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  function automatic logic [5:0] bench_idx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [5:0] r;
    for (int k = 0; k < 48; k++) begin
      logic fb;
      fb = c[0] ^ a[k];
      c = {1'b0, c[31:1]};
      if (fb) c = c ^ 32'hEDB8_8320;
    end
    c = ~c;
    for (int i = 0; i < 6; i++) r[i] = c[5-i];
    return r;
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_slot(input int n, input logic [47:0] a, input logic en);
    wr(16 + 2*n, a[31:0]);
    wr(17 + 2*n, {en, 15'd0, a[47:32]});
  endtask

  task automatic set_hash(input logic [63:0] t);
    wr(1, t[31:0]);
    wr(2, t[63:32]);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic s);
    @(negedge clk);
    in_valid = 1'b1; in_data = b; in_sof = s;
    @(posedge clk);
  endtask

  // Count decisions in the next n negedge samples
  task automatic watch(input int n, output int pulses, output int first, output logic acc);
    pulses = 0; first = 0; acc = 1'b0;
    for (int t = 1; t <= n; t++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0;
      if (dec_valid) begin
        if (pulses == 0) begin first = t; acc = dec_accept; end
        pulses++;
      end
    end
  endtask

  task automatic frame(input string req, input logic [47:0] a, input logic exp_acc);
    int pulses, first;
    logic acc;
    for (int i = 0; i < 6; i++) send_byte(a[i*8 +: 8], i == 0);
    watch(5, pulses, first, acc);
    check({req, " pulse count"}, 64'(pulses), 64'd1);
    check({req, " accept"}, 64'(acc), 64'(exp_acc));
  endtask

  task automatic t_reset();
    int pulses, first;
    logic acc;
    check("R12 dec_valid in reset", 64'(dec_valid), 64'd0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 in_ready after reset", 64'(in_ready), 64'd1);
    for (int i = 0; i < 6; i++) send_byte(UC_A[i*8 +: 8], 1'b0);
    watch(5, pulses, first, acc);
    check("R1 no decision before sof", 64'(pulses), 64'd0);
    for (int i = 0; i < 6; i++) send_byte(UC_A[i*8 +: 8], i == 0);
    watch(5, pulses, first, acc);
    check("R2 decision latency", 64'(first), 64'd2);
    check("R2 one pulse", 64'(pulses), 64'd1);
    check("R12 unicast dropped after reset", 64'(acc), 64'd0);
  endtask

  task automatic t_perfect();
    set_slot(0, UC_A, 1'b1);
    set_slot(16, UC_B, 1'b1);
    frame("R4 slot0 match", UC_A, 1'b1);
    frame("R4 slot16 match", UC_B, 1'b1);
    frame("R4 no match", UC_X, 1'b0);
    set_slot(16, UC_B, 1'b0);
    frame("R4 disabled slot", UC_B, 1'b0);
  endtask

  task automatic t_hash();
    logic [5:0] ix = bench_idx(MC_A);
    logic [63:0] one = 64'd1 << ix;
    set_hash(one);
    frame("R7 hash off ignores table", MC_A, 1'b0);
    wr(0, 32'h2);
    frame("R6 R7 hash bin set", MC_A, 1'b1);
    set_hash(~one);
    frame("R6 R7 only other bins set", MC_A, 1'b0);
    frame("R7 unicast ignores hash", UC_X, 1'b0);
    set_hash(64'd0);
    wr(0, 32'h0);
  endtask

  task automatic t_pass_mc();
    wr(0, 32'h4);
    frame("R8 group passes", MC_A, 1'b1);
    frame("R8 unicast unmatched", UC_X, 1'b0);
    wr(0, 32'h0);
    frame("R8 cleared group drops", MC_A, 1'b0);
  endtask

  task automatic t_bcast();
    frame("R9 broadcast accepted", BCAST, 1'b1);
    wr(0, 32'h8);
    frame("R9 broadcast disabled", BCAST, 1'b0);
  endtask

  task automatic t_promisc();
    wr(0, 32'h9);
    frame("R10 promisc unicast", UC_X, 1'b1);
    frame("R10 promisc over bcast off", BCAST, 1'b1);
    wr(0, 32'h0);
  endtask

  task automatic t_recv_all();
    wr(0, 32'h10);
    frame("R11 receive-all unicast", UC_X, 1'b1);
    frame("R5 R11 receive-all group", MC_A, 1'b1);
    wr(0, 32'h0);
  endtask

  task automatic t_restart();
    int pulses, first;
    logic acc;
    for (int i = 0; i < 3; i++) send_byte(UC_A[i*8 +: 8], i == 0);
    for (int i = 0; i < 6; i++) send_byte(UC_X[i*8 +: 8], i == 0);
    watch(5, pulses, first, acc);
    check("R3 one decision after restart", 64'(pulses), 64'd1);
    check("R3 verdict of restarted address", 64'(acc), 64'd0);
  endtask

  task automatic t_extra_bytes();
    int pulses, first;
    logic acc;
    frame("R1 frame before tail", UC_A, 1'b1);
    for (int i = 0; i < 6; i++) send_byte(8'hFF, 1'b0);
    watch(5, pulses, first, acc);
    check("R1 tail bytes ignored", 64'(pulses), 64'd0);
    check("R1 ready held", 64'(in_ready), 64'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_perfect();
    t_hash();
    t_pass_mc();
    t_bcast();
    t_promisc();
    t_recv_all();
    t_restart();
    t_extra_bytes();
    repeat (4) @(posedge clk);
    finish_run();
  end

endmodule